// File: doc/BRIEF.md
# Protected Bit Unlock Sequencer

This block keeps a few bits of two control registers, a bias register and a thermal register, safe from stray software writes. Both registers live inside the block. Each register is fully writable except for a set of protected bit positions, which a per-register mask parameter names. Software changes those protected bits by first writing a four-byte key, one byte per write, to a dedicated key address. That opens the protection. Writing the same key again closes it.

A small matcher follows the bytes written to the key address. A byte that breaks the key sends the matcher back to its start, unless that byte is the first key byte: then it counts as the start of a new attempt. Writes to any other address do not touch the matcher, so an interrupted key sequence can continue. While the protection is closed, a write to a guarded register still updates its unprotected bits and leaves the protected ones as they were. The block also exports, for each guarded register, the mask of bits that a write would currently change.

Top module: `guard_bit_lock`

## Requirements
- R1: After reset the protection is closed (`unlocked` = 0), the matcher waits for the first key byte, both guarded registers hold 0x00, and each write mask equals the inverse of its protected mask.
- R2: The key address is 0x57. Four writes to it with data 0x02, 0x10, 0x12, 0x00, in that order, toggle the protection. `unlocked` shows the new state from the clock edge that captures the fourth byte.
- R3: Writing the complete key a second time closes the protection again. Every further complete key toggles it once more.
- R4: A byte written to 0x57 that is not the expected key byte sends the matcher back to the start. If that byte is 0x02, it is taken as the first key byte of a new attempt.
- R5: Writes to other addresses, and cycles with `wr_en` low, leave a partly matched key where it is.
- R6: While closed, a write to the bias register (address 0x30, protected mask 0xC0) or to the thermal register (address 0x31, protected mask 0x0F) updates only the bits outside the protected mask. The protected bits keep their old values.
- R7: While open, a write to either guarded register updates all eight bits.
- R8: A guarded register changes only on a write to its own address. Key writes and writes to the other guarded register leave it unchanged.
- R9: `bias_wmask` and `therm_wmask` read 0xFF while open, and the inverse of the protected mask while closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data |
| bias_q | output | 8 | Current bias register contents |
| therm_q | output | 8 | Current thermal register contents |
| bias_wmask | output | 8 | Bits of the bias register a write would change now |
| therm_wmask | output | 8 | Bits of the thermal register a write would change now |
| unlocked | output | 1 | 1 while the protected bits are open for writing |

## Verification
The bench writes every byte value to the key address at each of the four key positions, then completes the rest of the key. It checks that only the expected byte leaves the matcher advancing. A matcher that failed to restart would then toggle on the tail, and one that ignored position would toggle on the wrong bytes. A directed sequence repeats the first key byte in the middle of the key, which exposes a matcher that drops a restarting 0x02, and another sequence breaks the key with other writes and idle cycles, which exposes a matcher that resets on unrelated traffic. Both guarded registers are swept through all 256 data values, once open and once closed with the protected bits set to one. A wrong protected mask, a write that goes through while closed, or a write that leaks into the other register then shows up as a wrong expected byte.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

    // Outcome of one cycle of the key matcher.
    typedef enum logic [2:0] {
        MK_IDLE,
        MK_NEXT,
        MK_DONE,
        MK_RESTART,
        MK_MISS
    } match_kind_e;

    localparam int          LK_KEY_LEN   = 4;
    localparam int          LK_DATA_W    = 8;
    localparam int          LK_ADDR_W    = 8;
    localparam logic [7:0]  LK_KEY_ADDR  = 8'h57;
    // First key byte in the most significant position.
    localparam logic [31:0] LK_KEY       = 32'h02_10_12_00;

endpackage

// File: rtl/lock_key_matcher.sv
module lock_key_matcher
    import lockseq_pkg::*;
#(
    parameter int                          ADDR_W   = 8,
    parameter int                          DATA_W   = 8,
    parameter int                          KEY_LEN  = 4,
    parameter logic [ADDR_W-1:0]           KEY_ADDR = 8'h57,
    parameter logic [KEY_LEN*DATA_W-1:0]   KEY      = 32'h02_10_12_00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlocked
);

    localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_LEN - 1);
    localparam logic [IDX_W-1:0] SECOND_IDX = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             open;
    } mstate_t;

    mstate_t st_d, st_q;

    logic [DATA_W-1:0] key_bytes [KEY_LEN];

    for (genvar k = 0; k < KEY_LEN; k++) begin : g_key
        assign key_bytes[k] = KEY[(KEY_LEN-1-k)*DATA_W +: DATA_W];
    end

    logic [DATA_W-1:0] expect_byte;
    match_kind_e       kind;

    assign expect_byte = key_bytes[st_q.idx];

    always_comb begin
        kind = MK_IDLE;
        if (wr_en && (wr_addr == KEY_ADDR)) begin
            if (wr_data == expect_byte) begin
                kind = (st_q.idx == LAST_IDX) ? MK_DONE : MK_NEXT;
            end else if (wr_data == key_bytes[0]) begin
                kind = MK_RESTART;
            end else begin
                kind = MK_MISS;
            end
        end

        st_d = st_q;
        unique case (kind)
            MK_NEXT:    st_d.idx = st_q.idx + SECOND_IDX;
            MK_DONE: begin
                st_d.idx  = '0;
                st_d.open = ~st_q.open;
            end
            MK_RESTART: st_d.idx = SECOND_IDX;
            MK_MISS:    st_d.idx = '0;
            default:    st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked = st_q.open;

endmodule

// File: rtl/guarded_reg.sv
module guarded_reg #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = '0,
    parameter logic [DATA_W-1:0] PROT_MASK = '0,
    parameter logic [DATA_W-1:0] RST_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              unlocked,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] wmask
);

    localparam logic [DATA_W-1:0] OPEN_MASK   = '1;
    localparam logic [DATA_W-1:0] CLOSED_MASK = ~PROT_MASK;

    logic [DATA_W-1:0] val_d, val_q;
    logic [DATA_W-1:0] mask_now;
    logic              hit;

    always_comb begin
        mask_now = unlocked ? OPEN_MASK : CLOSED_MASK;
        hit      = wr_en && (wr_addr == REG_ADDR);
        val_d    = val_q;
        if (hit) begin
            val_d = (val_q & ~mask_now) | (wr_data & mask_now);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= RST_VAL;
        end else begin
            val_q <= val_d;
        end
    end

    assign q     = val_q;
    assign wmask = mask_now;

endmodule

// File: rtl/guard_bit_lock.sv
module guard_bit_lock
    import lockseq_pkg::*;
#(
    parameter int                        ADDR_W     = 8,
    parameter int                        DATA_W     = 8,
    parameter int                        KEY_LEN    = 4,
    parameter logic [ADDR_W-1:0]         KEY_ADDR   = 8'h57,
    parameter logic [KEY_LEN*DATA_W-1:0] KEY        = 32'h02_10_12_00,
    parameter logic [ADDR_W-1:0]         BIAS_ADDR  = 8'h30,
    parameter logic [ADDR_W-1:0]         THERM_ADDR = 8'h31,
    parameter logic [DATA_W-1:0]         BIAS_PROT  = 8'hC0,
    parameter logic [DATA_W-1:0]         THERM_PROT = 8'h0F,
    parameter logic [DATA_W-1:0]         BIAS_RST   = 8'h00,
    parameter logic [DATA_W-1:0]         THERM_RST  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bias_q,
    output logic [DATA_W-1:0] therm_q,
    output logic [DATA_W-1:0] bias_wmask,
    output logic [DATA_W-1:0] therm_wmask,
    output logic              unlocked
);

    localparam int NUM_GUARD = 2;
    localparam logic [NUM_GUARD*ADDR_W-1:0] G_ADDRS = {THERM_ADDR, BIAS_ADDR};
    localparam logic [NUM_GUARD*DATA_W-1:0] G_PROT  = {THERM_PROT, BIAS_PROT};
    localparam logic [NUM_GUARD*DATA_W-1:0] G_RST   = {THERM_RST, BIAS_RST};

    logic [DATA_W-1:0] g_q    [NUM_GUARD];
    logic [DATA_W-1:0] g_mask [NUM_GUARD];
    logic              open_now;

    lock_key_matcher #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEY_LEN  (KEY_LEN),
        .KEY_ADDR (KEY_ADDR),
        .KEY      (KEY)
    ) i_matcher (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .unlocked (open_now)
    );

    for (genvar g = 0; g < NUM_GUARD; g++) begin : g_guard
        guarded_reg #(
            .ADDR_W    (ADDR_W),
            .DATA_W    (DATA_W),
            .REG_ADDR  (G_ADDRS[g*ADDR_W +: ADDR_W]),
            .PROT_MASK (G_PROT[g*DATA_W +: DATA_W]),
            .RST_VAL   (G_RST[g*DATA_W +: DATA_W])
        ) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .unlocked (open_now),
            .q        (g_q[g]),
            .wmask    (g_mask[g])
        );
    end

    assign bias_q      = g_q[0];
    assign therm_q     = g_q[1];
    assign bias_wmask  = g_mask[0];
    assign therm_wmask = g_mask[1];
    assign unlocked    = open_now;

endmodule

// File: rtl/guard_bit_lock_chk.sv
module guard_bit_lock_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h57,
    parameter logic [DATA_W-1:0] LAST_BYTE  = 8'h00,
    parameter logic [ADDR_W-1:0] BIAS_ADDR  = 8'h30,
    parameter logic [ADDR_W-1:0] THERM_ADDR = 8'h31,
    parameter logic [DATA_W-1:0] BIAS_PROT  = 8'hC0,
    parameter logic [DATA_W-1:0] THERM_PROT = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] bias_q,
    input logic [DATA_W-1:0] therm_q,
    input logic [DATA_W-1:0] bias_wmask,
    input logic [DATA_W-1:0] therm_wmask,
    input logic              unlocked
);

    // R2
    lock_toggle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked != $past(unlocked)) |->
            $past(wr_en && (wr_addr == KEY_ADDR) && (wr_data == LAST_BYTE)));

    // R6
    bias_prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ((bias_q & BIAS_PROT) == ($past(bias_q) & BIAS_PROT)));

    // R6
    therm_prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ((therm_q & THERM_PROT) == ($past(therm_q) & THERM_PROT)));

    // R6
    bias_free_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == BIAS_ADDR)) |=>
            ((bias_q & ~BIAS_PROT) == ($past(wr_data) & ~BIAS_PROT)));

    // R7
    bias_open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && wr_en && (wr_addr == BIAS_ADDR)) |=> (bias_q == $past(wr_data)));

    // R7
    therm_open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && wr_en && (wr_addr == THERM_ADDR)) |=> (therm_q == $past(wr_data)));

    // R8
    bias_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == BIAS_ADDR)) |=> $stable(bias_q));

    // R8
    therm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == THERM_ADDR)) |=> $stable(therm_q));

    // R9
    wmask_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> ((bias_wmask == '1) && (therm_wmask == '1)));

endmodule

bind guard_bit_lock guard_bit_lock_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .KEY_ADDR   (KEY_ADDR),
    .LAST_BYTE  (KEY[DATA_W-1:0]),
    .BIAS_ADDR  (BIAS_ADDR),
    .THERM_ADDR (THERM_ADDR),
    .BIAS_PROT  (BIAS_PROT),
    .THERM_PROT (THERM_PROT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .bias_q      (bias_q),
    .therm_q     (therm_q),
    .bias_wmask  (bias_wmask),
    .therm_wmask (therm_wmask),
    .unlocked    (unlocked)
);

// File: tb/test_guard_bit_lock.sv
`timescale 1ns/1ps
module test_guard_bit_lock;

    localparam logic [7:0] KADDR  = 8'h57;
    localparam logic [7:0] BADDR  = 8'h30;
    localparam logic [7:0] TADDR  = 8'h31;
    localparam logic [7:0] BPROT  = 8'hC0;
    localparam logic [7:0] TPROT  = 8'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] bias_q, therm_q, bias_wmask, therm_wmask;
    logic       unlocked;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] key [4];
    logic       exp_open;
    logic [7:0] exp_b, exp_t;

    always #2.5 clk = ~clk;

    guard_bit_lock i_guard_bit_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bias_q(bias_q), .therm_q(therm_q),
        .bias_wmask(bias_wmask), .therm_wmask(therm_wmask), .unlocked(unlocked)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_key();
        for (int i = 0; i < 4; i++) wr(KADDR, key[i]);
        exp_open = ~exp_open;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_open = 1'b0; exp_b = 8'h00; exp_t = 8'h00;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        key[0] = 8'h02; key[1] = 8'h10; key[2] = 8'h12; key[3] = 8'h00;
        exp_open = 1'b0; exp_b = '0; exp_t = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 unlocked", {7'd0, unlocked}, 8'h00);
        check("R1 bias", bias_q, 8'h00);
        check("R1 therm", therm_q, 8'h00);
        check("R1 bias_wmask", bias_wmask, ~BPROT);
        check("R1 therm_wmask", therm_wmask, ~TPROT);

        // R2 three bytes do not open, fourth does
        for (int i = 0; i < 3; i++) wr(KADDR, key[i]);
        check("R2 partial key", {7'd0, unlocked}, 8'h00);
        wr(KADDR, key[3]);
        exp_open = 1'b1;
        check("R2 full key", {7'd0, unlocked}, 8'h01);
        check("R9 bias_wmask open", bias_wmask, 8'hFF);
        check("R9 therm_wmask open", therm_wmask, 8'hFF);
        check("R8 key leaves bias", bias_q, exp_b);

        // R3 second key closes, third reopens
        send_key();
        check("R3 relock", {7'd0, unlocked}, {7'd0, exp_open});
        check("R9 bias_wmask closed", bias_wmask, ~BPROT);
        send_key();
        check("R3 reopen", {7'd0, unlocked}, {7'd0, exp_open});

        // R7 open sweep, R8 other register untouched
        for (int d = 0; d < 256; d++) begin
            wr(BADDR, 8'(d)); exp_b = 8'(d);
            check("R7 bias open", bias_q, exp_b);
            check("R8 therm untouched", therm_q, exp_t);
        end
        for (int d = 0; d < 256; d++) begin
            wr(TADDR, 8'(d)); exp_t = 8'(d);
            check("R7 therm open", therm_q, exp_t);
            check("R8 bias untouched", bias_q, exp_b);
        end

        // close, protected bits now all ones
        send_key();
        check("R3 close before sweep", {7'd0, unlocked}, 8'h00);
        check("R8 key leaves therm", therm_q, exp_t);

        // R6 closed sweep
        for (int d = 0; d < 256; d++) begin
            wr(BADDR, 8'(d));
            exp_b = (exp_b & BPROT) | (8'(d) & ~BPROT);
            check("R6 bias closed", bias_q, exp_b);
        end
        for (int d = 0; d < 256; d++) begin
            wr(TADDR, 8'(d));
            exp_t = (exp_t & TPROT) | (8'(d) & ~TPROT);
            check("R6 therm closed", therm_q, exp_t);
        end

        // R4 restart on repeated first byte
        do_reset();
        wr(KADDR, 8'h02); wr(KADDR, 8'h10); wr(KADDR, 8'h02);
        wr(KADDR, 8'h10); wr(KADDR, 8'h12); wr(KADDR, 8'h00);
        check("R4 0x02 restarts", {7'd0, unlocked}, 8'h01);

        // R5 other traffic inside a key
        do_reset();
        wr(KADDR, 8'h02);
        wr(BADDR, 8'h15); exp_b = 8'h15;
        wr(KADDR, 8'h10);
        @(negedge clk); wr_addr = KADDR; wr_data = 8'h77; @(negedge clk);
        wr(8'h56, 8'h55);
        wr(TADDR, 8'h20); exp_t = 8'h20;
        wr(KADDR, 8'h12);
        wr(KADDR, 8'h00);
        check("R5 interrupted key opens", {7'd0, unlocked}, 8'h01);
        check("R5 bias write done", bias_q, exp_b);
        check("R5 therm write done", therm_q, exp_t);

        // R4 sweep of every byte at every key position
        do_reset();
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 256; b++) begin
                for (int i = 0; i < k; i++) wr(KADDR, key[i]);
                wr(KADDR, 8'(b));
                for (int i = k + 1; i < 4; i++) wr(KADDR, key[i]);
                if (8'(b) == key[k]) exp_open = ~exp_open;
                check("R4 byte sweep", {7'd0, unlocked}, {7'd0, exp_open});
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule